// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is one DMA channel that works through a chain of transfer descriptors held in memory. Software gives it the address of the first descriptor and a link-enable setting, then pulses a start strobe. The channel reads the descriptor, copies one frame from the source address to the destination address, and then either loads the next descriptor in the chain or stops. Each descriptor carries its own packed control words. These select the address modes, the bus width, constant fill and the interrupt events for that descriptor. A chain whose last entry points back to its first runs as a ring of periods with no software help until it is aborted.

Descriptor reads and data moves share one memory request port. The port has a ready signal and an in-order read response. A peripheral on either side of a transfer is reduced to a single ready input that paces each beat. While a transfer runs, two outputs show the bytes left in the current descriptor and the pointer to the descriptor that comes next, so software can compute the residue.

Top module: `dma_ll_channel`

## Requirements
- R1: After reset, busy, mem_req, irq_block and irq_list are low, and remain_cnt and next_desc are zero.
- R2: A descriptor fetch is nine word reads at ascending addresses head+0 to head+32. Data movement starts only after all nine responses have arrived. The words are, in order: next pointer, source, destination, frame length (low 20 bits), source stride, destination stride, control A, control B, fill value.
- R3: In word mode each beat reads one 32-bit word at the source address and then writes it to the destination address. The descriptor ends when its frame length is used up.
- R4: The address mode fields are control A bits 21:20 (source) and 23:22 (destination). Code 0 holds the address, code 1 adds the beat size after each beat, and code 2 adds the descriptor's stride word after each beat.
- R5: When control A bit 28 is set, each beat moves one byte. The read is issued with mem_byte high, the byte is taken from the lane selected by source address bits 1:0, and it is written with mem_byte high, copied to all four lanes of mem_wdata.
- R6: When control A bit 29 is set, no source reads are issued and every beat writes the descriptor's fill word.
- R7: After a descriptor, the channel fetches from the next pointer only if link_en is high, control A bit 30 is set and the pointer is nonzero. Otherwise the list ends. A pointer back to an earlier descriptor makes the chain run until it is aborted.
- R8: If control B bit 18 is set, irq_block pulses for one cycle after a descriptor's last write. If control B bit 19 is set, irq_list pulses for one cycle when the list ends, and the channel is already idle in that cycle.
- R9: While pause is high, no read request is issued and remain_cnt holds. When pause is released the transfer continues where it stopped.
- R10: The type fields are control A bits 17:16 (source) and 19:18 (destination). Code 0 marks a device, and a beat touching a device starts only while dev_ready is high.
- R11: A start strobe with start_val=1 while idle makes busy high in the next cycle. A start strobe with start_val=1 while busy is ignored. A start strobe with start_val=0 ends the channel at the next beat or fetch boundary, and no further data is written.
- R12: remain_cnt equals the frame length after a descriptor is loaded and drops by the beat size on each write. next_desc shows the next pointer of the current descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_wr | input | 1 | Strobe for the start register |
| start_val | input | 1 | Value written: 1 start, 0 abort |
| pause | input | 1 | Level: holds the channel at the next boundary |
| link_en | input | 1 | Channel-level enable for following next pointers |
| head_ptr | input | AW | Address of the first descriptor |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_byte | output | 1 | Request is a single byte |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted in this cycle |
| mem_rvalid | input | 1 | Read response valid (in order) |
| mem_rdata | input | 32 | Read response data |
| dev_ready | input | 1 | Peripheral can take or give a beat |
| busy | output | 1 | Channel active |
| remain_cnt | output | LEN_W | Bytes left in the current descriptor |
| next_desc | output | AW | Next pointer of the current descriptor |
| irq_block | output | 1 | One-cycle end-of-descriptor event |
| irq_list | output | 1 | One-cycle end-of-list event |

## Verification
The bench tests the main copy path with several patterns. Incrementing word copies check beat order and data. Stride and held destination addresses show that the two address fields are decoded separately and are not swapped. An unaligned byte-mode source shows whether the lane is selected correctly. Constant fill shows that source reads are dropped entirely. A two-entry ring run with link_en high, and then again with link_en low, separates the channel-level and per-descriptor link gates. Memory stalls, pause, a held dev_ready and an abort during a ring refetch show that the request order does not depend on back-pressure, and that no write escapes after an abort.

// File: rtl/dma_ll_pkg.sv
package dma_ll_pkg;
   localparam int DESC_WORDS = 9;
   // word index inside a descriptor
   localparam int W_NEXT = 0;
   localparam int W_SRC  = 1;
   localparam int W_DST  = 2;
   localparam int W_LEN  = 3;
   localparam int W_SSTR = 4;
   localparam int W_DSTR = 5;
   localparam int W_CTLA = 6;
   localparam int W_CTLB = 7;
   localparam int W_FILL = 8;
   // control A fields
   localparam int A_STYPE = 16;
   localparam int A_DTYPE = 18;
   localparam int A_SMODE = 20;
   localparam int A_DMODE = 22;
   localparam int A_BYTE  = 28;
   localparam int A_FILL  = 29;
   localparam int A_LINK  = 30;
   // control B event enables
   localparam int B_BLK  = 18;
   localparam int B_LIST = 19;

   localparam logic [1:0] TY_DEV = 2'd0;

   typedef enum logic [1:0] {
      AM_CONST  = 2'd0,
      AM_INC    = 2'd1,
      AM_STRIDE = 2'd2,
      AM_HOLD   = 2'd3
   } amode_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_FWAIT, ST_LOAD, ST_BEAT, ST_RWAIT, ST_WRITE
   } st_e;
endpackage

// File: rtl/dma_ll_desc_store.sv
module dma_ll_desc_store
   import dma_ll_pkg::*;
#(
   parameter int WORDS = DESC_WORDS
)(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [$clog2(WORDS)-1:0]         wr_idx,
   input  logic [31:0]                      wr_data,
   output logic [WORDS-1:0][31:0]           words
);
   localparam int IW = $clog2(WORDS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         words <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < WORDS; i++) begin
            if (wr_idx == IW'(i)) words[i] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/dma_ll_addr_unit.sv
module dma_ll_addr_unit
   import dma_ll_pkg::*;
#(
   parameter int AW = 32
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   input  amode_e        mode,
   input  logic [AW-1:0] inc,
   input  logic [AW-1:0] stride,
   output logic [AW-1:0] addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (load) begin
         addr <= load_val;
      end else if (step) begin
         case (mode)
            AM_INC:    addr <= addr + inc;
            AM_STRIDE: addr <= addr + stride;
            default:   addr <= addr;
         endcase
      end
   end
endmodule

// File: rtl/dma_ll_channel.sv
module dma_ll_channel
   import dma_ll_pkg::*;
#(
   parameter int AW    = 32,
   parameter int LEN_W = 20
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_wr,
   input  logic             start_val,
   input  logic             pause,
   input  logic             link_en,
   input  logic [AW-1:0]    head_ptr,
   output logic             mem_req,
   output logic             mem_we,
   output logic             mem_byte,
   output logic [AW-1:0]    mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic             mem_ready,
   input  logic             mem_rvalid,
   input  logic [31:0]      mem_rdata,
   input  logic             dev_ready,
   output logic             busy,
   output logic [LEN_W-1:0] remain_cnt,
   output logic [AW-1:0]    next_desc,
   output logic             irq_block,
   output logic             irq_list
);
   localparam int IW = $clog2(DESC_WORDS);

   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("dma_ll_channel: AW must be 8..32");
   end
   if (LEN_W < 3 || LEN_W > 32) begin : g_bad_len
      $error("dma_ll_channel: LEN_W must be 3..32");
   end

   st_e                        st;
   logic [IW-1:0]              idx;
   logic [AW-1:0]              fptr;
   logic                       abort_q;
   logic [31:0]                data_q;
   logic [LEN_W-1:0]           remain_q;
   logic [AW-1:0]              next_q;
   logic [DESC_WORDS-1:0][31:0] dw;

   // descriptor field decode
   logic [31:0] ctla, ctlb;
   logic        byte_m, fill_m, link_b;
   logic [1:0]  stype, dtype;
   assign ctla   = dw[W_CTLA];
   assign ctlb   = dw[W_CTLB];
   assign byte_m = ctla[A_BYTE];
   assign fill_m = ctla[A_FILL];
   assign link_b = ctla[A_LINK];
   assign stype  = ctla[A_STYPE +: 2];
   assign dtype  = ctla[A_DTYPE +: 2];

   logic unused_fields;
   assign unused_fields = ^{ctla, ctlb, dw[W_NEXT], dw[W_SRC], dw[W_DST],
                            dw[W_LEN], dw[W_SSTR], dw[W_DSTR]};

   logic [AW-1:0]    inc_v;
   logic [LEN_W-1:0] step_len;
   assign inc_v    = byte_m ? AW'(1) : AW'(4);
   assign step_len = byte_m ? LEN_W'(1) : LEN_W'(4);

   dma_ll_desc_store #(.WORDS(DESC_WORDS)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (st == ST_FWAIT && mem_rvalid),
      .wr_idx  (idx),
      .wr_data (mem_rdata),
      .words   (dw)
   );

   // address units: 0 = source, 1 = destination
   logic [AW-1:0] cur_addr [2];
   logic [AW-1:0] ld_val   [2];
   logic [AW-1:0] strd     [2];
   amode_e        am       [2];
   logic          wr_acc;

   assign ld_val[0] = dw[W_SRC][AW-1:0];
   assign ld_val[1] = dw[W_DST][AW-1:0];
   assign strd[0]   = dw[W_SSTR][AW-1:0];
   assign strd[1]   = dw[W_DSTR][AW-1:0];
   assign am[0]     = amode_e'(ctla[A_SMODE +: 2]);
   assign am[1]     = amode_e'(ctla[A_DMODE +: 2]);

   for (genvar g = 0; g < 2; g++) begin : g_addr
      dma_ll_addr_unit #(.AW(AW)) u_au (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (st == ST_LOAD),
         .load_val (ld_val[g]),
         .step     (wr_acc),
         .mode     (am[g]),
         .inc      (inc_v),
         .stride   (strd[g]),
         .addr     (cur_addr[g])
      );
   end

   logic       dev_ok, beat_go, last_beat, follow, desc_end, empty_desc;
   logic [7:0] lane_b;

   assign dev_ok     = (stype != TY_DEV || dev_ready) && (dtype != TY_DEV || dev_ready);
   assign beat_go    = (st == ST_BEAT) && !abort_q && !pause && dev_ok;
   assign last_beat  = remain_q <= step_len;
   assign wr_acc     = (st == ST_WRITE) && mem_ready;
   assign empty_desc = (dw[W_LEN][LEN_W-1:0] == '0);
   assign follow     = link_en && link_b && (dw[W_NEXT][AW-1:0] != '0);
   assign desc_end   = (wr_acc && last_beat) || (st == ST_LOAD && empty_desc);
   assign lane_b     = 8'(mem_rdata >> {cur_addr[0][1:0], 3'b000});

   // memory port
   assign mem_req   = (st == ST_FETCH && !abort_q && !pause) ||
                      (beat_go && !fill_m) || (st == ST_WRITE);
   assign mem_we    = (st == ST_WRITE);
   assign mem_byte  = (st == ST_BEAT || st == ST_WRITE) && byte_m;
   assign mem_addr  = (st == ST_FETCH) ? fptr + (AW'(idx) << 2) :
                      (st == ST_WRITE) ? cur_addr[1] : cur_addr[0];
   assign mem_wdata = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         idx       <= '0;
         fptr      <= '0;
         abort_q   <= 1'b0;
         data_q    <= '0;
         remain_q  <= '0;
         next_q    <= '0;
         irq_block <= 1'b0;
         irq_list  <= 1'b0;
      end else begin
         irq_block <= 1'b0;
         irq_list  <= 1'b0;
         if (start_wr && !start_val && st != ST_IDLE) abort_q <= 1'b1;
         case (st)
            ST_IDLE: begin
               abort_q <= 1'b0;
               if (start_wr && start_val) begin
                  fptr <= head_ptr;
                  idx  <= '0;
                  st   <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (abort_q)                  st <= ST_IDLE;
               else if (!pause && mem_ready) st <= ST_FWAIT;
            end
            ST_FWAIT: begin
               if (mem_rvalid) begin
                  if (idx == IW'(DESC_WORDS - 1)) begin
                     st <= ST_LOAD;
                  end else begin
                     idx <= idx + 1'b1;
                     st  <= ST_FETCH;
                  end
               end
            end
            ST_LOAD: begin
               remain_q <= dw[W_LEN][LEN_W-1:0];
               next_q   <= dw[W_NEXT][AW-1:0];
               st       <= ST_BEAT;
            end
            ST_BEAT: begin
               if (abort_q) begin
                  st <= ST_IDLE;
               end else if (beat_go) begin
                  if (fill_m) begin
                     data_q <= dw[W_FILL];
                     st     <= ST_WRITE;
                  end else if (mem_ready) begin
                     st <= ST_RWAIT;
                  end
               end
            end
            ST_RWAIT: begin
               if (mem_rvalid) begin
                  data_q <= byte_m ? {4{lane_b}} : mem_rdata;
                  st     <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (mem_ready) begin
                  remain_q <= last_beat ? '0 : remain_q - step_len;
                  st       <= ST_BEAT;
               end
            end
            default: st <= ST_IDLE;
         endcase
         if (desc_end) begin
            irq_block <= ctlb[B_BLK];
            if (follow) begin
               fptr <= dw[W_NEXT][AW-1:0];
               idx  <= '0;
               st   <= ST_FETCH;
            end else begin
               irq_list <= ctlb[B_LIST];
               st       <= ST_IDLE;
            end
         end
      end
   end

   assign busy       = (st != ST_IDLE);
   assign remain_cnt = remain_q;
   assign next_desc  = next_q;
endmodule

// File: rtl/dma_ll_chk.sv
module dma_ll_chk (
   input logic clk,
   input logic rst_n,
   input logic start_wr,
   input logic start_val,
   input logic pause,
   input logic mem_req,
   input logic mem_we,
   input logic busy,
   input logic irq_block,
   input logic irq_list
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   assert_pause_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> !pause);

   assert_list_event_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_list |-> !busy);

   assert_block_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_block |=> !irq_block);

   assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr && start_val && !busy) |=> busy);
endmodule

bind dma_ll_channel dma_ll_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_wr  (start_wr),
   .start_val (start_val),
   .pause     (pause),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .busy      (busy),
   .irq_block (irq_block),
   .irq_list  (irq_list)
);

// File: tb/sim_dma_ll_channel.sv
module sim_dma_ll_channel;
   localparam int AW = 32;
   localparam int LW = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_wr = 0, start_val = 0, pause = 0, link_en = 0, dev_ready = 1;
   logic [AW-1:0] head_ptr = '0;
   logic mem_req, mem_we, mem_byte, mem_ready, mem_rvalid;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic busy, irq_block, irq_list;
   logic [LW-1:0] remain_cnt;
   logic [AW-1:0] next_desc;

   always #4 clk = ~clk;

   dma_ll_channel #(.AW(AW), .LEN_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_val(start_val),
      .pause(pause), .link_en(link_en), .head_ptr(head_ptr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .dev_ready(dev_ready),
      .busy(busy), .remain_cnt(remain_cnt), .next_desc(next_desc),
      .irq_block(irq_block), .irq_list(irq_list));

   // ---------------- memory model ----------------
   logic [31:0] mem [0:1023];
   int  cyc = 0;
   bit  stall = 0;
   logic rv_q = 0;
   logic [31:0] rd_q = '0;
   assign mem_ready  = !stall || (cyc % 3 != 0);
   assign mem_rvalid = rv_q;
   assign mem_rdata  = rd_q;

   always @(posedge clk) begin
      rv_q <= mem_req && !mem_we && mem_ready;
      rd_q <= mem[mem_addr[11:2]];
      if (mem_req && mem_we && mem_ready) begin
         if (mem_byte)
            mem[mem_addr[11:2]][8*mem_addr[1:0] +: 8] <= mem_wdata[7:0];
         else
            mem[mem_addr[11:2]] <= mem_wdata;
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      bit          we;
      bit          by;
      logic [31:0] a;
      logic [31:0] d;
   } ev_t;
   ev_t expq[$];
   int  n_cmp = 0, n_bad = 0;
   int  blk_cnt = 0, lst_cnt = 0, wr_cnt = 0, rd_cnt = 0;
   int  exp_blk = 0, exp_lst = 0;
   bit  allow_extra = 0;
   bit  done = 0;
   string cur_tag = "R1";

   task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", r, act, exp);
      end
   endtask

   // compared on every clock: each accepted request against the model
   always @(negedge clk) begin
      ev_t e;
      if (rst_n) begin
         if (irq_block) blk_cnt++;
         if (irq_list)  lst_cnt++;
         if (mem_req && mem_ready) begin
            if (mem_we) wr_cnt++; else rd_cnt++;
            if (expq.size() == 0) begin
               if (mem_we || !allow_extra) begin
                  n_cmp++; n_bad++;
                  $display("FAIL R11: unexpected request actual addr %h we %0d expected none",
                           mem_addr, mem_we);
               end
            end else begin
               e = expq.pop_front();
               n_cmp++;
               if (e.we != mem_we || e.by != mem_byte || e.a != mem_addr ||
                   (e.we && e.d != mem_wdata)) begin
                  n_bad++;
                  $display("FAIL %s: actual addr %h data %h we %0d byte %0d expected addr %h data %h we %0d byte %0d",
                           cur_tag, mem_addr, mem_wdata, mem_we, mem_byte, e.a, e.d, e.we, e.by);
               end
            end
         end
      end
   end

   // ---------------- behavioural reference ----------------
   function automatic logic [31:0] mk_a(int sm, int dm, int sty, int dty, bit by, bit fl, bit lk);
      return (32'(sty) << 16) | (32'(dty) << 18) | (32'(sm) << 20) | (32'(dm) << 22) |
             (32'(by) << 28) | (32'(fl) << 29) | (32'(lk) << 30);
   endfunction

   function automatic logic [31:0] adv(logic [31:0] a, logic [1:0] m, int st, logic [31:0] s);
      if (m == 2'd1) return a + 32'(st);
      if (m == 2'd2) return a + s;
      return a;
   endfunction

   task automatic put_desc(input int base, input logic [31:0] nx, src, dst, len, ss, ds, ca, cb, fv);
      mem[base/4 + 0] = nx;  mem[base/4 + 1] = src; mem[base/4 + 2] = dst;
      mem[base/4 + 3] = len; mem[base/4 + 4] = ss;  mem[base/4 + 5] = ds;
      mem[base/4 + 6] = ca;  mem[base/4 + 7] = cb;  mem[base/4 + 8] = fv;
   endtask

   task automatic push(input bit we, input bit by, input logic [31:0] a, input logic [31:0] d);
      ev_t e;
      e.we = we; e.by = by; e.a = a; e.d = d;
      expq.push_back(e);
   endtask

   task automatic walk(input logic [31:0] head, input bit len_en, input int maxd);
      logic [31:0] p;
      p = head;
      exp_blk = 0; exp_lst = 0;
      for (int d = 0; d < maxd; d++) begin
         logic [31:0] w [9];
         logic [31:0] s, t, dat;
         int rem, stp;
         bit by, fl;
         for (int k = 0; k < 9; k++) begin
            push(0, 0, p + 32'(4*k), 0);
            w[k] = mem[p/4 + 32'(k)];
         end
         by = w[6][28]; fl = w[6][29];
         stp = by ? 1 : 4;
         rem = int'(w[3][19:0]);
         s = w[1]; t = w[2];
         while (rem > 0) begin
            if (!fl) push(0, by, s, 0);
            if (fl) dat = w[8];
            else if (by) dat = {4{8'(mem[s[11:2]] >> (8*s[1:0]))}};
            else dat = mem[s[11:2]];
            push(1, by, t, dat);
            s = adv(s, w[6][21:20], stp, w[4]);
            t = adv(t, w[6][23:22], stp, w[5]);
            rem = (rem > stp) ? rem - stp : 0;
         end
         if (w[7][18]) exp_blk++;
         if (len_en && w[6][30] && w[0] != 0) p = w[0];
         else begin
            if (w[7][19]) exp_lst++;
            break;
         end
      end
   endtask

   // ---------------- stimulus helpers ----------------
   task automatic start_ch(input logic [31:0] h);
      @(posedge clk); #1;
      head_ptr = h; start_wr = 1; start_val = 1;
      @(posedge clk); #1;
      start_wr = 0;
      @(negedge clk);
      chk(busy == 1'b1, "R11 start", 32'(busy), 1);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_check(input int b0, input int l0);
      chk(expq.size() == 0, {cur_tag, " all requests seen"}, expq.size(), 0);
      chk(blk_cnt - b0 == exp_blk, "R8 block events", blk_cnt - b0, exp_blk);
      chk(lst_cnt - l0 == exp_lst, "R8 list events", lst_cnt - l0, exp_lst);
      chk(busy == 1'b0, "R11 idle", 32'(busy), 0);
   endtask

   task automatic run_list(input string tag, input logic [31:0] h, input bit le);
      int b0, l0;
      cur_tag = tag; link_en = le;
      walk(h, le, 8);
      b0 = blk_cnt; l0 = lst_cnt;
      start_ch(h);
      wait_idle();
      finish_check(b0, l0);
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int b0, l0, w0, r0, rc0, lw0;
      for (int i = 0; i < 1024; i++) mem[i] = 32'(i) * 32'h9E3779B1 ^ 32'h5A5A0F0F;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(busy == 0 && mem_req == 0, "R1 busy/req", {busy, mem_req}, 0);
      chk(irq_block == 0 && irq_list == 0, "R1 events", {irq_block, irq_list}, 0);
      chk(remain_cnt == 0, "R1 remain", 32'(remain_cnt), 0);
      chk(next_desc == 0, "R1 next", next_desc, 0);

      // R2 R3: plain word copy, link disabled
      put_desc(32'h000, 0, 32'h400, 32'h800, 16, 0, 0, mk_a(1,1,2,2,0,0,1), 32'h1 << 19, 0);
      run_list("R3", 32'h000, 0);

      // R4 R7: two-entry chain, stride modes, memory stalls
      stall = 1;
      put_desc(32'h040, 32'h080, 32'h480, 32'h880, 8, 0, 12, mk_a(1,2,2,2,0,0,1), 32'h1 << 18, 0);
      put_desc(32'h080, 0, 32'h4C0, 32'h8C0, 12, 8, 0, mk_a(2,1,2,2,0,0,1), 32'h3 << 18, 0);
      run_list("R4", 32'h040, 1);
      stall = 0;

      // R5: byte mode, unaligned source, held destination
      put_desc(32'h0C0, 0, 32'h501, 32'h900, 5, 0, 0, mk_a(1,0,2,2,1,0,0), 32'h1 << 19, 0);
      run_list("R5", 32'h0C0, 0);
      chk(mem[32'h900/4][7:0] == 8'(mem[32'h504/4] >> 8), "R5 last byte held dst",
          32'(mem[32'h900/4][7:0]), 32'(8'(mem[32'h504/4] >> 8)));

      // R6: constant fill
      put_desc(32'h100, 0, 32'h540, 32'h940, 12, 0, 0, mk_a(1,1,2,2,0,1,0), 32'h1 << 19, 32'hCAFEF00D);
      run_list("R6", 32'h100, 0);

      // R9 R12 R11: pause mid-copy, residue, start while busy ignored
      cur_tag = "R9"; link_en = 0;
      put_desc(32'h140, 0, 32'h600, 32'hA00, 64, 0, 0, mk_a(1,1,2,2,0,0,0), 32'h1 << 19, 0);
      walk(32'h140, 0, 8);
      b0 = blk_cnt; l0 = lst_cnt; w0 = wr_cnt;
      start_ch(32'h140);
      while (wr_cnt - w0 < 3) @(negedge clk);
      @(posedge clk); #1 pause = 1;
      repeat (4) @(negedge clk);
      chk(remain_cnt == LW'(64 - 4*(wr_cnt - w0)), "R12 residue", 32'(remain_cnt), 64 - 4*(wr_cnt - w0));
      chk(next_desc == 0, "R12 next pointer", next_desc, 0);
      r0 = int'(remain_cnt); rc0 = rd_cnt;
      @(posedge clk); #1 head_ptr = 32'h000; start_wr = 1; start_val = 1;
      @(posedge clk); #1 start_wr = 0;
      repeat (16) @(negedge clk);
      chk(int'(remain_cnt) == r0, "R9 remain held", 32'(remain_cnt), r0);
      chk(rd_cnt == rc0, "R9 no reads", rd_cnt, rc0);
      @(posedge clk); #1 pause = 0;
      wait_idle();
      finish_check(b0, l0);

      // R10: device destination waits for dev_ready
      cur_tag = "R10"; dev_ready = 0;
      put_desc(32'h180, 32'h040, 32'h680, 32'hAC0, 8, 0, 0, mk_a(1,0,2,0,0,0,1), 32'h1 << 19, 0);
      walk(32'h180, 0, 8);
      b0 = blk_cnt; l0 = lst_cnt; w0 = wr_cnt;
      start_ch(32'h180);
      repeat (40) @(negedge clk);
      chk(wr_cnt == w0, "R10 no write while device not ready", wr_cnt - w0, 0);
      chk(remain_cnt == 8, "R12 loaded length", 32'(remain_cnt), 8);
      chk(next_desc == 32'h040, "R12 next pointer shown", next_desc, 32'h040);
      @(posedge clk); #1 dev_ready = 1;
      wait_idle();
      finish_check(b0, l0);

      // R7 R11: cyclic ring, abort after three periods
      cur_tag = "R7"; link_en = 1; allow_extra = 1;
      put_desc(32'h1C0, 32'h200, 32'h700, 32'hB00, 8, 0, 0, mk_a(1,1,2,2,0,0,1), 32'h1 << 18, 0);
      put_desc(32'h200, 32'h1C0, 32'h740, 32'hB40, 8, 0, 0, mk_a(1,1,2,2,0,0,1), 32'h1 << 18, 0);
      walk(32'h1C0, 1, 3);
      b0 = blk_cnt; l0 = lst_cnt; lw0 = wr_cnt;
      start_ch(32'h1C0);
      while (blk_cnt - b0 < 3) @(negedge clk);
      @(posedge clk); #1 start_wr = 1; start_val = 0;
      @(posedge clk); #1 start_wr = 0;
      wait_idle();
      repeat (4) @(negedge clk);
      finish_check(b0, l0);
      chk(wr_cnt - lw0 == 6, "R11 no write after abort", wr_cnt - lw0, 6);
      allow_extra = 0;

      // R7: same ring with the channel-level link off runs one entry
      run_list("R7", 32'h1C0, 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule